// File: doc/BRIEF.md
# Registered/Latched Bidirectional Bus Transceiver

This block links two 18-bit buses, called A and B, and carries data in both directions without inverting it. Each direction has its own storage element and three controls: an output enable, a latch enable and a capture clock. When the latch enable is high, the element is transparent and the far bus follows the near bus. When the latch enable is low, the element keeps its value until a rising clock edge loads new data. The B-side drivers switch on when the A-to-B enable is high. The A-side drivers switch on when the B-to-A enable is low.

An active-low power-up reset turns off both sets of drivers at once and clears both storage elements. The reset is applied asynchronously. Its release reaches the edge-triggered part of each direction through a synchronizer clocked by that direction's capture clock. The buses are modelled as inout ports. Inside the block each direction keeps a plain input value, a stored value and an enable, and these are joined at the ports by high-impedance drive.

Top module: `xcvr_bus_transceiver`

## Requirements
- R1: With `ab_le` high and `ab_oe` high, `b_bus` equals `a_bus` bit for bit in the same cycle, with no inversion.
- R2: With `ab_le` low and no rising edge on `ab_clk`, `b_bus` keeps its value even when `a_bus` changes.
- R3: With `ab_le` low, a rising edge on `ab_clk` loads `a_bus`, and `b_bus` shows the loaded value from that edge until the next edge.
- R4: While `ab_le` is high, edges on `ab_clk` have no effect beyond transparency. When `ab_le` falls, `b_bus` keeps the value that was present at the fall, even if an earlier edge had loaded a different value.
- R5: `ab_oe` high drives `b_bus`. `ab_oe` low releases `b_bus`, so a value placed on it from outside reads back unchanged.
- R6: The B-to-A direction behaves as in R1 to R4, using `ba_le` and `ba_clk`. Its output enable `ba_oe_n` is active low: 0 drives `a_bus` and 1 releases it.
- R7: A storage element keeps loading or following its input while its outputs are released. The new value appears as soon as the outputs are enabled again.
- R8: While `rst_n` is low, both buses are released whatever the enables are. After release, both stored values read as zero until they are loaded.
- R9: After `rst_n` rises, the first two rising edges of a direction's clock load nothing. The third edge loads the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_bus | inout | 18 | A-side bus; input of the A-to-B direction, output of the B-to-A direction |
| b_bus | inout | 18 | B-side bus; output of the A-to-B direction, input of the B-to-A direction |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ab_le | input | 1 | A-to-B latch enable; high is transparent |
| ab_clk | input | 1 | A-to-B capture clock, rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable; high is transparent |
| ba_clk | input | 1 | B-to-A capture clock, rising edge |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assertion |

## Verification
Two functions can fall in the same cycle. A clock edge can arrive while the latch enable is high, and a load can happen while the outputs are released. The bench pulses the capture clock in a step where the latch enable is high and expects pure transparency. It then lowers the latch enable and expects the value present at the fall, not the one from the earlier load. In a separate case it loads new data while the bench itself drives the released bus. It judges release by reading back its own pattern, and judges the hidden load by the value that appears when the enable returns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_W = 18;

  // Which source feeds a direction's output mux.
  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,  // transparent: input straight through
    SRC_LAT  = 2'd1,  // value closed in by the falling latch enable
    SRC_REG  = 2'd2   // value loaded by the most recent clock edge
  } out_src_e;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  localparam int SH_W = (STAGES < 2) ? 2 : STAGES;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[SH_W-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign rst_s_n = sh_q[SH_W-1];

  // The synchronized release never rises while the raw reset is held.
  assert_sync_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_s_n) |-> $past(rst_n));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W           = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] y
);

  logic         rst_s_n;
  logic [W-1:0] lat_q;
  logic [W-1:0] reg_q;
  logic [W-1:0] reg_nxt;
  logic         cap_en;
  logic         fresh_q;
  out_src_e     src;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // Level-sensitive stage: follows d while le is high, closes when le falls.
  always_latch begin
    if (!rst_n)  lat_q <= '0;
    else if (le) lat_q <= d;
  end

  // Edge stage: loads only while the latch enable is low.
  assign cap_en = ~le;

  always_comb begin
    reg_nxt = cap_en ? d : reg_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) reg_q <= '0;
    else          reg_q <= reg_nxt;
  end

  // Marks that the edge stage is newer than the level stage.
  always_ff @(posedge clk or negedge rst_s_n or posedge le) begin
    if (!rst_s_n) fresh_q <= 1'b0;
    else if (le)  fresh_q <= 1'b0;
    else          fresh_q <= 1'b1;
  end

  always_comb begin
    if (le)           src = SRC_PASS;
    else if (fresh_q) src = SRC_REG;
    else              src = SRC_LAT;
  end

  always_comb begin
    case (src)
      SRC_PASS: y = d;
      SRC_REG:  y = reg_q;
      SRC_LAT:  y = lat_q;
      default:  y = lat_q;
    endcase
  end

  // An edge seen with the latch enable low loads the input present at that edge.
  assert_edge_load_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !le |=> (reg_q == $past(d)));

endmodule

// File: rtl/xcvr_bus_transceiver.sv
module xcvr_bus_transceiver #(
  parameter int WIDTH       = xcvr_pkg::XCVR_W,
  parameter int SYNC_STAGES = 2
) (
  inout  wire  [WIDTH-1:0] a_bus,
  inout  wire  [WIDTH-1:0] b_bus,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             rst_n
);

  logic [WIDTH-1:0] ab_y;
  logic [WIDTH-1:0] ba_y;
  logic             b_drv_en;
  logic             a_drv_en;

  xcvr_lane #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_lane_ab (
    .clk   (ab_clk),
    .rst_n (rst_n),
    .le    (ab_le),
    .d     (a_bus),
    .y     (ab_y)
  );

  xcvr_lane #(.W(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_lane_ba (
    .clk   (ba_clk),
    .rst_n (rst_n),
    .le    (ba_le),
    .d     (b_bus),
    .y     (ba_y)
  );

  // Opposite enable polarities; reset overrides both asynchronously.
  assign b_drv_en = ab_oe & rst_n;
  assign a_drv_en = ~ba_oe_n & rst_n;

  assign b_bus = b_drv_en ? ab_y : {WIDTH{1'bz}};
  assign a_bus = a_drv_en ? ba_y : {WIDTH{1'bz}};

  // Transparent and enabled: the far bus mirrors the near bus.
  assert_pass_ab_R1: assert property (@(posedge ab_clk) disable iff (!rst_n)
    (ab_le && ab_oe) |-> (b_bus == a_bus));

  assert_pass_ba_R6: assert property (@(posedge ba_clk) disable iff (!rst_n)
    (ba_le && !ba_oe_n) |-> (a_bus == b_bus));

endmodule

// File: tb/xcvr_bus_transceiver_tb.sv
module xcvr_bus_transceiver_tb;

  localparam int W  = 18;
  localparam int NV = 20;

  // Vector: [43:40] req, [39] dir (0 = A->B, 1 = B->A), [38] le, [37] clock pulse,
  //         [36] output enabled, [35:18] input data, [17:0] expected output side.
  // With output disabled the bench drives the expected pattern on the output side.
  localparam logic [43:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h15A5A, 18'h15A5A},  // R1 pass
    {4'd1, 1'b0, 1'b1, 1'b0, 1'b1, 18'h2C3C3, 18'h2C3C3},  // R1 follows
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 18'h2C3C3, 18'h2C3C3},  // R2 close
    {4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00FF0, 18'h2C3C3},  // R2 hold
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 18'h00FF0, 18'h00FF0},  // R3 load
    {4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 18'h00FF0},  // R3 hold
    {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h3FFFF},  // R3 load
    {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 18'h12345, 18'h0ABCD},  // R5 released
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 18'h12345, 18'h0ABCD},  // R7 load while released
    {4'd7, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h12345},  // R7 re-enable
    {4'd4, 1'b0, 1'b1, 1'b1, 1'b1, 18'h05555, 18'h05555},  // R4 edge while pass
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h05555, 18'h05555},  // R4 close
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h05555},  // R4 latched wins
    {4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R4 reopen
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA},  // R4 close again
    {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h2AAAA},  // R4 hold after older load
    {4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 18'h0F0F0, 18'h0F0F0},  // R6 pass B->A
    {4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 18'h31337, 18'h31337},  // R6 load B->A
    {4'd6, 1'b1, 1'b0, 1'b1, 1'b0, 18'h2468A, 18'h1BEEF},  // R6 released, R7 load
    {4'd7, 1'b1, 1'b0, 1'b0, 1'b1, 18'h00000, 18'h2468A}   // R7 re-enable B->A
  };

  logic         clk;
  logic         rst_n;
  logic         ab_oe, ab_le, ab_ce;
  logic         ba_oe_n, ba_le, ba_ce;
  logic         tb_a_en, tb_b_en;
  logic [W-1:0] tb_a, tb_b;
  wire          ab_clk;
  wire          ba_clk;
  wire  [W-1:0] a_bus;
  wire  [W-1:0] b_bus;
  int           n_cmp;
  int           n_bad;
  logic         done;

  assign ab_clk = clk & ab_ce;
  assign ba_clk = clk & ba_ce;
  assign a_bus  = tb_a_en ? tb_a : {W{1'bz}};
  assign b_bus  = tb_b_en ? tb_b : {W{1'bz}};

  xcvr_bus_transceiver u_dut (
    .a_bus   (a_bus),
    .b_bus   (b_bus),
    .ab_oe   (ab_oe),
    .ab_le   (ab_le),
    .ab_clk  (ab_clk),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_clk  (ba_clk),
    .rst_n   (rst_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp,
                       input int req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
    end
    // Contention guard: bench and block never drive one bus together (R5, R6).
    n_cmp++;
    if ((tb_b_en && ab_oe && rst_n) || (tb_a_en && !ba_oe_n && rst_n)) begin
      n_bad++;
      $display("FAIL R5 contention on %s: actual 1 expected 0", what);
    end
  endtask

  task automatic pulse_ab(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ab_ce = 1'b1;
      @(negedge clk); ab_ce = 1'b0;
    end
  endtask

  task automatic run_vec(input logic [43:0] v, input int idx);
    logic         dir, le, pl, oe;
    logic [W-1:0] d, e;
    dir = v[39]; le = v[38]; pl = v[37]; oe = v[36];
    d = v[35:18]; e = v[17:0];
    @(negedge clk);
    if (!dir) begin
      ba_oe_n = 1'b1; ba_le = 1'b0; ba_ce = 1'b0;
      tb_b_en = !oe;  tb_b = e;
      ab_oe = oe;     ab_le = le; ab_ce = pl;
      tb_a_en = 1'b1; tb_a = d;
    end else begin
      ab_oe = 1'b0;   ab_le = 1'b0; ab_ce = 1'b0;
      tb_a_en = !oe;  tb_a = e;
      ba_oe_n = !oe;  ba_le = le; ba_ce = pl;
      tb_b_en = 1'b1; tb_b = d;
    end
    @(posedge clk);
    #1;
    check(dir ? a_bus : b_bus, e, int'(v[43:40]), $sformatf("vector %0d", idx));
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0;
    ab_le = 1'b0; ab_ce = 1'b0; ab_oe = 1'b1;
    ba_le = 1'b0; ba_ce = 1'b0; ba_oe_n = 1'b0;
    tb_a_en = 1'b1; tb_a = 18'h11111;
    tb_b_en = 1'b1; tb_b = 18'h22222;

    // R8: held in reset with both enables active, both buses released.
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;
    if (a_bus !== 18'h11111 || b_bus !== 18'h22222) begin
      n_bad++;
      $display("FAIL R8 reset release: actual %h/%h expected 11111/22222", a_bus, b_bus);
    end

    // R8: after release, the A->B stored value reads zero.
    @(negedge clk);
    tb_b_en = 1'b0; ba_oe_n = 1'b1;
    rst_n = 1'b1;
    #1;
    check(b_bus, 18'h00000, 8, "cleared after reset");

    // R9: two edges ignored, the third loads.
    pulse_ab(2);
    #1;
    check(b_bus, 18'h00000, 9, "first two edges ignored");
    pulse_ab(1);
    #1;
    check(b_bus, 18'h11111, 9, "third edge loads");

    // Bring the B->A release through its synchronizer with transparency on.
    @(negedge clk);
    ba_le = 1'b1;
    repeat (3) begin
      @(negedge clk); ba_ce = 1'b1;
      @(negedge clk); ba_ce = 1'b0;
    end
    ba_le = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R8: reset in mid-run releases both buses and clears stored data.
    @(negedge clk);
    ab_ce = 1'b0; ba_ce = 1'b0; ab_le = 1'b0; ba_le = 1'b0;
    rst_n = 1'b0;
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    tb_a_en = 1'b1; tb_a = 18'h3C3C3;
    tb_b_en = 1'b1; tb_b = 18'h0C0C0;
    #1;
    check(b_bus, 18'h0C0C0, 8, "mid-run reset B released");
    check(a_bus, 18'h3C3C3, 8, "mid-run reset A released");
    @(negedge clk);
    tb_b_en = 1'b0; ba_oe_n = 1'b1;
    rst_n = 1'b1;
    #1;
    check(b_bus, 18'h00000, 8, "A->B cleared mid-run");
    @(negedge clk);
    ab_oe = 1'b0; tb_b_en = 1'b1; tb_b = 18'h0C0C0;
    tb_a_en = 1'b0; ba_oe_n = 1'b0;
    #1;
    check(a_bus, 18'h00000, 8, "B->A cleared mid-run");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule